// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block plays out, one T-state per clock, the machine cycles a small 8-bit CPU runs when it accepts a maskable interrupt. A one-clock `start` pulse latches the interrupt mode, the return address, the stack pointer, the interrupt page register and a flag that says whether a device in mode 0 puts a CALL or a restart opcode on the bus. The sequencer then walks through the acknowledge cycle, any operand or vector reads, and the two stack pushes. During each T-state it shows a cycle-type code, the bus address and, for writes, the byte being written.

At the end it gives the new program counter and stack pointer. It also raises a one-clock completion pulse that carries the number of T-states used, so the caller can check its timing. In every mode the acknowledge cycle is two T-states longer than the normal opcode fetch of the instruction it stands for. A restart fetch is 5 T-states and a CALL fetch is 4.

Top module: `int_ack_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy` = 0, `done` = 0 and `cyc` = 0 (idle).
- R2: Mode 1 (`mode` = 1) runs one acknowledge of 7 T-states, then two stack writes of 3 T-states each, 13 T-states in all. The new PC is 0x0038.
- R3: Mode 0 with `ins_call` = 0 runs one acknowledge of 7 T-states, then two stack writes of 3 T-states each. The byte sampled on `data_in` in the last acknowledge T-state is a restart opcode. The new PC is that opcode's bits 5:3 times 8.
- R4: Mode 0 with `ins_call` = 1 runs an acknowledge of 6 T-states. It then reads the operand low byte in 3 T-states at address PC and the operand high byte in 4 T-states at address PC+1, followed by the two stack writes, 19 T-states in all. The new PC is {high, low}.
- R5: Mode 2 runs an acknowledge of 7 T-states and the two stack writes. It then reads 3 T-states at address {I, ack byte with bit 0 cleared} and 3 T-states at that address plus one, 19 T-states in all. The new PC is {second byte, first byte}.
- R6: The first stack write goes to SP-1 with PC[15:8] and the second goes to SP-2 with PC[7:0], both modulo 2^16. The new SP is SP-2.
- R7: `cyc` is 0 when idle, 1 during acknowledge, 2 during a memory read and 3 during a memory write. `busy` is high for every T-state of the sequence. The address during the acknowledge cycle is the latched PC.
- R8: In the clock after the last T-state, `done` is high for exactly one clock, `busy` is low, and `tstates` equals the number of T-states the sequence took.
- R9: A `start` pulse while `busy` is high is ignored. Inputs that change after `start` has been accepted have no effect on the running sequence or its results.
- R10: Mode code 3 behaves exactly like mode 1.
- R11: The first T-state, an acknowledge, appears in the clock after the clock in which `start` was sampled high while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept an interrupt (sampled while idle) |
| mode | input | 2 | Interrupt mode 0..3 |
| ins_call | input | 1 | Mode 0: device inserts CALL (1) or restart (0) |
| pc_in | input | 16 | Return address to push |
| sp_in | input | 16 | Stack pointer before the pushes |
| ireg_in | input | 8 | Interrupt page register |
| data_in | input | 8 | Data bus, sampled in the last T-state of acknowledge and read cycles |
| busy | output | 1 | Sequence in progress |
| cyc | output | 2 | Cycle type of the current T-state |
| addr | output | 16 | Bus address of the current T-state |
| wdata | output | 8 | Byte written in write cycles, 0 otherwise |
| done | output | 1 | One-clock completion pulse |
| tstates | output | 8 | T-state count of the last sequence |
| new_pc | output | 16 | Program counter after the sequence |
| new_sp | output | 16 | Stack pointer after the sequence |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, 8-bit data, fetch lengths of 5 and 4, two extra acknowledge T-states, 3-T reads and writes, and a 4-T high operand read. At these sizes a sweep of every mode code against all eight restart opcodes is cheap. The sweep uses stack pointers at 0x0000 and 0x0001, so the pushes wrap. It uses interrupt page values 0x00 and 0xFF with odd acknowledge bytes, so the vector address lands on 0xFFFE/0xFFFF. Each T-state's cycle code, address and write byte is compared with a schedule the bench derives from the mode. Start pulses are injected in mid-sequence, and inputs are scrambled after acceptance.

// File: rtl/int_ack_pkg.sv
// Package: shared cycle-type codes and step kinds for the interrupt
// acknowledge sequencer. Assumes a 2-bit cycle code on the bus side.
package int_ack_pkg;

    // Bus cycle type shown on every T-state
    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_ACK  = 2'd1,
        CYC_RD   = 2'd2,
        CYC_WR   = 2'd3
    } cyc_e;

    // Machine-cycle kinds a sequence can be built from
    typedef enum logic [2:0] {
        ST_ACK   = 3'd0,
        ST_OPL   = 3'd1,
        ST_OPH   = 3'd2,
        ST_PSH_H = 3'd3,
        ST_PSH_L = 3'd4,
        ST_VEC_L = 3'd5,
        ST_VEC_H = 3'd6
    } step_e;

    localparam int MAX_STEPS = 5;
    localparam int IDX_W     = $clog2(MAX_STEPS);

endpackage

// File: rtl/int_ack_plan.sv
// Module: int_ack_plan
// Maps (latched mode, inserted-CALL flag, step index) to the kind of
// machine cycle, its length in T-states and whether it is the last one.
// Purely combinational. Assumes mode code 3 is handled as mode 1.
module int_ack_plan
    import int_ack_pkg::*;
#(
    parameter int RST_FETCH_T  = 5,
    parameter int CALL_FETCH_T = 4,
    parameter int ACK_EXTRA    = 2,
    parameter int RD_T         = 3,
    parameter int CALL_HI_T    = 4,
    parameter int WR_T         = 3,
    parameter int TCNT_W       = 4
) (
    input  logic [1:0]        mode_q,
    input  logic              call_q,
    input  logic [IDX_W-1:0]  idx,
    output step_e             kind,
    output logic [TCNT_W-1:0] len,
    output logic              last
);

    localparam int ACK_LONG  = RST_FETCH_T + ACK_EXTRA;
    localparam int ACK_SHORT = CALL_FETCH_T + ACK_EXTRA;

    logic sel_call;
    logic sel_vec;

    assign sel_call = (mode_q == 2'd0) && call_q;
    assign sel_vec  = (mode_q == 2'd2);

    // Select the step kind, length and end flag for the current index
    always_comb begin
        kind = ST_ACK;
        len  = TCNT_W'(ACK_LONG);
        last = 1'b0;
        if (sel_call) begin
            case (idx)
                IDX_W'(0): begin kind = ST_ACK;   len = TCNT_W'(ACK_SHORT); end
                IDX_W'(1): begin kind = ST_OPL;   len = TCNT_W'(RD_T);      end
                IDX_W'(2): begin kind = ST_OPH;   len = TCNT_W'(CALL_HI_T); end
                IDX_W'(3): begin kind = ST_PSH_H; len = TCNT_W'(WR_T);      end
                default:   begin kind = ST_PSH_L; len = TCNT_W'(WR_T); last = 1'b1; end
            endcase
        end else if (sel_vec) begin
            case (idx)
                IDX_W'(0): begin kind = ST_ACK;   len = TCNT_W'(ACK_LONG); end
                IDX_W'(1): begin kind = ST_PSH_H; len = TCNT_W'(WR_T);     end
                IDX_W'(2): begin kind = ST_PSH_L; len = TCNT_W'(WR_T);     end
                IDX_W'(3): begin kind = ST_VEC_L; len = TCNT_W'(RD_T);     end
                default:   begin kind = ST_VEC_H; len = TCNT_W'(RD_T); last = 1'b1; end
            endcase
        end else begin
            case (idx)
                IDX_W'(0): begin kind = ST_ACK;   len = TCNT_W'(ACK_LONG); end
                IDX_W'(1): begin kind = ST_PSH_H; len = TCNT_W'(WR_T);     end
                default:   begin kind = ST_PSH_L; len = TCNT_W'(WR_T); last = 1'b1; end
            endcase
        end
    end

endmodule

// File: rtl/int_ack_timer.sv
// Module: int_ack_timer
// Counts T-states inside each machine cycle, steps through the plan,
// totals the T-states and emits the completion pulse. Assumes len >= 1.
module int_ack_timer
    import int_ack_pkg::*;
#(
    parameter int TCNT_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TCNT_W-1:0] len,
    input  logic              last,
    output logic              active,
    output logic [IDX_W-1:0]  idx,
    output logic              step_end,
    output logic              done,
    output logic [CNT_W-1:0]  total
);

    logic [TCNT_W-1:0] tcnt;
    logic [CNT_W-1:0]  run_cnt;

    assign step_end = active && (tcnt == len - TCNT_W'(1));

    // Advance T-state and step counters; raise done after the final T-state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            idx     <= '0;
            tcnt    <= '0;
            run_cnt <= '0;
            done    <= 1'b0;
            total   <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    idx     <= '0;
                    tcnt    <= '0;
                    run_cnt <= '0;
                end
            end else begin
                run_cnt <= run_cnt + CNT_W'(1);
                if (step_end) begin
                    tcnt <= '0;
                    if (last) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                        total  <= run_cnt + CNT_W'(1);
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end else begin
                    tcnt <= tcnt + TCNT_W'(1);
                end
            end
        end
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_end_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> done);
    a_r11_begin_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && start) |=> active);
    a_r7_tcnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (tcnt < len));

endmodule

// File: rtl/int_ack_bus.sv
// Module: int_ack_bus
// Drives cycle type, address and write byte for the current step,
// captures bytes read from the bus and forms the new PC and SP.
// Assumes the address is exactly two data bytes wide.
module int_ack_bus
    import int_ack_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter logic [15:0] FIXED_TGT = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  step_e             kind,
    input  logic              step_end,
    input  logic [1:0]        mode_q,
    input  logic              call_q,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [ADDR_W-1:0] sp_q,
    input  logic [DATA_W-1:0] i_q,
    input  logic [DATA_W-1:0] data_in,
    output logic [1:0]        cyc,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] new_pc,
    output logic [ADDR_W-1:0] new_sp
);

    logic [DATA_W-1:0] ack_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic [ADDR_W-1:0] vec_addr;

    assign vec_addr = {i_q, ack_q[DATA_W-1:1], 1'b0};
    assign new_sp   = sp_q - ADDR_W'(2);

    // Bus view of the current T-state
    always_comb begin
        cyc   = CYC_IDLE;
        addr  = pc_q;
        wdata = '0;
        if (active) begin
            case (kind)
                ST_ACK:   cyc = CYC_ACK;
                ST_OPL:   cyc = CYC_RD;
                ST_OPH:   begin cyc = CYC_RD; addr = pc_q + ADDR_W'(1); end
                ST_PSH_H: begin cyc = CYC_WR; addr = sp_q - ADDR_W'(1);
                                wdata = pc_q[ADDR_W-1:DATA_W]; end
                ST_PSH_L: begin cyc = CYC_WR; addr = sp_q - ADDR_W'(2);
                                wdata = pc_q[DATA_W-1:0]; end
                ST_VEC_L: begin cyc = CYC_RD; addr = vec_addr; end
                ST_VEC_H: begin cyc = CYC_RD; addr = vec_addr + ADDR_W'(1); end
                default:  cyc = CYC_IDLE;
            endcase
        end
    end

    // Capture the bus byte at the end of acknowledge and read cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (step_end) begin
            case (kind)
                ST_ACK:           ack_q <= data_in;
                ST_OPL, ST_VEC_L: lo_q  <= data_in;
                ST_OPH, ST_VEC_H: hi_q  <= data_in;
                default:          ;
            endcase
        end
    end

    // Resume address chosen by mode
    always_comb begin
        if (mode_q == 2'd2 || (mode_q == 2'd0 && call_q))
            new_pc = {hi_q, lo_q};
        else if (mode_q == 2'd0)
            new_pc = ADDR_W'({ack_q[5:3], 3'b000});
        else
            new_pc = ADDR_W'(FIXED_TGT);
    end

    a_r6_write_has_data_source: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_WR) |-> (kind == ST_PSH_H || kind == ST_PSH_L));

endmodule

// File: rtl/int_ack_seq.sv
// Module: int_ack_seq (top)
// Interrupt acknowledge sequencer: on start, latches the context and
// runs the acknowledge, operand/vector reads and stack pushes one
// T-state per clock. Assumes start is only honoured while idle.
module int_ack_seq
    import int_ack_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int CNT_W        = 8,
    parameter int RST_FETCH_T  = 5,
    parameter int CALL_FETCH_T = 4,
    parameter int ACK_EXTRA    = 2,
    parameter int RD_T         = 3,
    parameter int CALL_HI_T    = 4,
    parameter int WR_T         = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic              ins_call,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [DATA_W-1:0] ireg_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output logic [1:0]        cyc,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              done,
    output logic [CNT_W-1:0]  tstates,
    output logic [ADDR_W-1:0] new_pc,
    output logic [ADDR_W-1:0] new_sp
);

    localparam int STEP_BOUND = RST_FETCH_T + CALL_FETCH_T + ACK_EXTRA
                              + RD_T + CALL_HI_T + WR_T;
    localparam int TCNT_W     = $clog2(STEP_BOUND + 1);

    logic [1:0]        mode_q;
    logic              call_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] sp_q;
    logic [DATA_W-1:0] i_q;
    logic [IDX_W-1:0]  idx;
    step_e             kind;
    logic [TCNT_W-1:0] len;
    logic              last;
    logic              step_end;
    logic              take;

    assign take = start && !busy;

    // Latch the interrupt context when a sequence is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            call_q <= 1'b0;
            pc_q   <= '0;
            sp_q   <= '0;
            i_q    <= '0;
        end else if (take) begin
            mode_q <= mode;
            call_q <= ins_call;
            pc_q   <= pc_in;
            sp_q   <= sp_in;
            i_q    <= ireg_in;
        end
    end

    int_ack_plan #(
        .RST_FETCH_T (RST_FETCH_T),
        .CALL_FETCH_T(CALL_FETCH_T),
        .ACK_EXTRA   (ACK_EXTRA),
        .RD_T        (RD_T),
        .CALL_HI_T   (CALL_HI_T),
        .WR_T        (WR_T),
        .TCNT_W      (TCNT_W)
    ) i_plan (
        .mode_q(mode_q),
        .call_q(call_q),
        .idx   (idx),
        .kind  (kind),
        .len   (len),
        .last  (last)
    );

    int_ack_timer #(
        .TCNT_W(TCNT_W),
        .CNT_W (CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .len     (len),
        .last    (last),
        .active  (busy),
        .idx     (idx),
        .step_end(step_end),
        .done    (done),
        .total   (tstates)
    );

    int_ack_bus #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (busy),
        .kind    (kind),
        .step_end(step_end),
        .mode_q  (mode_q),
        .call_q  (call_q),
        .pc_q    (pc_q),
        .sp_q    (sp_q),
        .i_q     (i_q),
        .data_in (data_in),
        .cyc     (cyc),
        .addr    (addr),
        .wdata   (wdata),
        .new_pc  (new_pc),
        .new_sp  (new_sp)
    );

    initial begin
        a_r5_bus_width: assert (ADDR_W == 2 * DATA_W);
    end

    a_r7_first_is_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cyc == CYC_ACK));
    a_r9_context_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(pc_q) && $stable(sp_q) && $stable(mode_q)));

endmodule

// File: tb/test_int_ack_seq.sv
// Bench: sweeps every mode code against all restart opcodes and edge
// values of PC, SP and I; expected schedules computed arithmetically.
module test_int_ack_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  mode_i;
    logic        call_i;
    logic [15:0] pc_i, sp_i;
    logic [7:0]  ireg_i, data_in, dev_q;
    logic        busy, done;
    logic [1:0]  cyc;
    logic [15:0] addr, new_pc, new_sp;
    logic [7:0]  wdata, tstates;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    int_ack_seq i_int_ack_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_i),
        .ins_call(call_i), .pc_in(pc_i), .sp_in(sp_i), .ireg_in(ireg_i),
        .data_in(data_in), .busy(busy), .cyc(cyc), .addr(addr),
        .wdata(wdata), .done(done), .tstates(tstates),
        .new_pc(new_pc), .new_sp(new_sp)
    );

    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'h96;
    endfunction

    // Device and memory model on the data bus
    always_comb data_in = (cyc == 2'd1) ? dev_q : mem(addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [1:0] m, input logic c,
                            input logic [15:0] p, input logic [15:0] s,
                            input logic [7:0] iv, input logic [7:0] dv,
                            input int poke);
        int n, tot, t;
        int lens[5];
        logic [1:0]  cy[5];
        logic [15:0] ad[5];
        logic [7:0]  wd[5];
        logic [15:0] epc, va;
        string tg;
        va = {iv, dv & 8'hFE};
        for (int k = 0; k < 5; k++) wd[k] = 8'h00;
        if (m == 2'd0 && c) begin
            n = 5; tg = "R4";
            lens = '{6, 3, 4, 3, 3};
            cy = '{2'd1, 2'd2, 2'd2, 2'd3, 2'd3};
            ad = '{p, p, p + 16'd1, s - 16'd1, s - 16'd2};
            wd[3] = p[15:8]; wd[4] = p[7:0];
            epc = {mem(p + 16'd1), mem(p)};
        end else if (m == 2'd2) begin
            n = 5; tg = "R5";
            lens = '{7, 3, 3, 3, 3};
            cy = '{2'd1, 2'd3, 2'd3, 2'd2, 2'd2};
            ad = '{p, s - 16'd1, s - 16'd2, va, va + 16'd1};
            wd[1] = p[15:8]; wd[2] = p[7:0];
            epc = {mem(va + 16'd1), mem(va)};
        end else begin
            n = 3;
            tg = (m == 2'd0) ? "R3" : ((m == 2'd3) ? "R10" : "R2");
            lens = '{7, 3, 3, 0, 0};
            cy = '{2'd1, 2'd3, 2'd3, 2'd0, 2'd0};
            ad = '{p, s - 16'd1, s - 16'd2, 16'd0, 16'd0};
            wd[1] = p[15:8]; wd[2] = p[7:0];
            epc = (m == 2'd0) ? {8'h00, dv & 8'h38} : 16'h0038;
        end
        tot = 0;
        for (int k = 0; k < n; k++) tot += lens[k];

        @(negedge clk);
        mode_i = m; call_i = c; pc_i = p; sp_i = s; ireg_i = iv; dev_q = dv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // scramble inputs after acceptance (R9)
        mode_i = ~m; call_i = ~c; pc_i = ~p; sp_i = ~s; ireg_i = ~iv;
        chk(busy && cyc == 2'd1, "R11", "first T-state ack", {cyc, busy}, 3'b011);
        t = 0;
        for (int st = 0; st < n; st++) begin
            for (int k = 0; k < lens[st]; k++) begin
                chk(busy === 1'b1 && cyc === cy[st] && addr === ad[st],
                    (poke >= 0) ? "R9" : tg, "R7 cyc/addr per T-state",
                    {14'd0, cyc, addr}, {14'd0, cy[st], ad[st]});
                if (cy[st] == 2'd3)
                    chk(wdata === wd[st], "R6", "stack write byte", wdata, wd[st]);
                start = (t == poke);
                t++;
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R8", "done pulse / busy low",
            {done, busy}, 2'b10);
        chk(tstates === 8'(tot), "R8", "T-state total", tstates, tot);
        chk(new_pc === epc, tg, "new PC", new_pc, epc);
        chk(new_sp === s - 16'd2, "R6", "new SP", new_sp, s - 16'd2);
        @(negedge clk);
        chk(done === 1'b0 && cyc === 2'd0, "R8", "done one clock, idle",
            {done, cyc}, 3'b000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; mode_i = 2'd0; call_i = 1'b0;
        pc_i = 16'h0; sp_i = 16'h0; ireg_i = 8'h0; dev_q = 8'h0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && cyc === 2'd0, "R1",
            "reset state", {busy, done, cyc}, 4'b0000);
        rst_n = 1'b1;
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 2; c++) begin
                for (int k = 0; k < 8; k++) begin
                    logic [15:0] p, s;
                    logic [7:0] iv, dv;
                    p  = (k == 0) ? 16'hFFFF : 16'h1234 + 16'(k * 16'h0F11);
                    s  = (k == 1) ? 16'h0000 : ((k == 2) ? 16'h0001 : 16'h8000 - 16'(k * 2));
                    iv = (k[0]) ? 8'hFF : 8'(k * 8'h25);
                    dv = 8'hC7 | 8'(k << 3);
                    if (k == 7) dv = 8'hFF;
                    run_case(2'(m), 1'(c), p, s, iv, dv, -1);
                end
            end
        end
        // start pulses in mid-sequence are ignored (R9)
        run_case(2'd1, 1'b0, 16'hABCD, 16'h4000, 8'h12, 8'hD7, 4);
        run_case(2'd0, 1'b1, 16'h00FF, 16'h0002, 8'h00, 8'h00, 9);
        run_case(2'd2, 1'b0, 16'h7FFE, 16'hFFFF, 8'hFF, 8'hFF, 15);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule